// File: doc/BRIEF.md
# DRAM Self-Refresh Entry/Exit Sequencer

This block decides when the DRAM goes into self-refresh and when it comes back out, inside a DDR memory controller. A single control bit requests self-refresh. Software owns that bit through a one-bit write port. A hardware request pin can also set it, but only a software write of 0 clears it. Once the bit is set, the block holds the command scheduler and waits until no burst is in flight. If any bank is open, it issues precharge-all and waits a loadable precharge time. It then issues the self-refresh command and drops clock enable on the next cycle.

The device stays in self-refresh until the bit reads 0. The block then raises clock enable at once. It waits a loadable exit time and after that a loadable DLL relock time, using one down-counter for both waits. Only then does it release the scheduler hold. The scheduler was frozen, not flushed, so it resumes at the command where it stopped. All interfaces are plain level or pulse signals, because no data stream passes through the block.

Top module: `sref_seq`

## Requirements
- R1: The control bit is 0 after reset. A cycle with `cfg_wr_en` high loads it from `cfg_wr_data`. A cycle with `sref_req_pin` high sets it to 1, even if a write of 0 happens in the same cycle. Only a write of 0 with the pin low clears it.
- R2: `sched_hold` is high whenever the control bit is 1, and also whenever an entry, self-refresh or exit sequence is in progress. It is high in the cycle right after the bit becomes 1.
- R3: After a request, neither `cmd_pre_all` nor `cmd_sref` is issued while `burst_idle` is low.
- R4: In the first cycle the block sees `burst_idle` high, any bit of `banks_open` set means `cmd_pre_all` pulses for exactly one cycle on the next cycle. If no bank is open, precharge is skipped and `cmd_sref` follows on the next cycle.
- R5: After precharge-all, `cmd_sref` is issued max(`trp_cycles`,1)+1 cycles after the `cmd_pre_all` cycle.
- R6: `cmd_sref` is a one-cycle pulse with `cke` still high. `cke` is low from the next cycle on.
- R7: `cke` stays low and `in_sref` stays high for as long as the control bit is 1. If the bit is cleared during entry, entry still completes before exit starts.
- R8: `cke` returns high one cycle after the control bit reads 0 while in self-refresh.
- R9: After `cke` rises, `sched_hold` stays high for max(`txsr_cycles`,1)+max(`dll_cycles`,1) cycles. It then drops, unless the bit has been set again, in which case a new entry begins.
- R10: After reset, `cke`=1, and `cmd_pre_all`, `cmd_sref`, `in_sref` and `sched_hold` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe for the control bit |
| cfg_wr_data | input | 1 | Value to write to the control bit |
| sref_req_pin | input | 1 | Hardware request; sets the control bit |
| burst_idle | input | 1 | High when no burst is in flight |
| banks_open | input | NUM_BANKS | One bit per bank, high when the bank is open |
| trp_cycles | input | CNT_W | Precharge wait, in cycles |
| txsr_cycles | input | CNT_W | Self-refresh exit wait, in cycles |
| dll_cycles | input | CNT_W | DLL relock wait, in cycles |
| cmd_pre_all | output | 1 | Precharge-all command pulse |
| cmd_sref | output | 1 | Self-refresh entry command pulse |
| cke | output | 1 | DRAM clock enable |
| in_sref | output | 1 | Device is in self-refresh |
| sched_hold | output | 1 | Stops the scheduler from issuing commands |

## Verification
The bench targets the pin-versus-write conflict in a single cycle. A design that let the write win there would never enter self-refresh. It clears the bit during a stalled drain: a wrong design would abandon entry with banks half closed, or would drop clock enable without a self-refresh command. It uses zero-valued waits, where an off-by-one counter either skips the wait or wraps to a huge count. It also requests self-refresh again during the exit wait, where a faulty block would release the hold for a cycle or lose the new request.

// File: rtl/sref_pkg.sv
package sref_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DRAIN = 3'd1,
    ST_PRE   = 3'd2,
    ST_TRP   = 3'd3,
    ST_CMD   = 3'd4,
    ST_SR    = 3'd5,
    ST_XSR   = 3'd6,
    ST_DLL   = 3'd7
  } sref_state_e;
endpackage

// File: rtl/sref_ctrl_reg.sv
module sref_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_data,
  input  logic req_pin,
  output logic bit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bit_q <= 1'b0;
    else if (req_pin) bit_q <= 1'b1;
    else if (wr_en)   bit_q <= wr_data;
  end
endmodule

// File: rtl/sref_timer.sv
module sref_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (load)                      cnt_q <= load_val;
    else if (dec && cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/sref_fsm.sv
module sref_fsm
  import sref_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sref_bit,
  input  logic                 burst_idle,
  input  logic [NUM_BANKS-1:0] banks_open,
  input  logic [CNT_W-1:0]     trp_cycles,
  input  logic [CNT_W-1:0]     txsr_cycles,
  input  logic [CNT_W-1:0]     dll_cycles,
  input  logic                 tmr_expired,
  output logic                 tmr_load,
  output logic [CNT_W-1:0]     tmr_val,
  output logic                 tmr_dec,
  output sref_state_e          state_q
);
  sref_state_e state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (sref_bit) state_d = ST_DRAIN;
      ST_DRAIN: if (burst_idle) state_d = (|banks_open) ? ST_PRE : ST_CMD;
      ST_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = trp_cycles;
        state_d  = ST_TRP;
      end
      ST_TRP: begin
        tmr_dec = 1'b1;
        if (tmr_expired) state_d = ST_CMD;
      end
      ST_CMD:   state_d = ST_SR;
      ST_SR: begin
        if (!sref_bit) begin
          tmr_load = 1'b1;
          tmr_val  = txsr_cycles;
          state_d  = ST_XSR;
        end
      end
      ST_XSR: begin
        tmr_dec = 1'b1;
        if (tmr_expired) begin
          tmr_load = 1'b1;
          tmr_val  = dll_cycles;
          state_d  = ST_DLL;
        end
      end
      ST_DLL: begin
        tmr_dec = 1'b1;
        if (tmr_expired) state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/sref_seq.sv
module sref_seq
  import sref_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic                 cfg_wr_data,
  input  logic                 sref_req_pin,
  input  logic                 burst_idle,
  input  logic [NUM_BANKS-1:0] banks_open,
  input  logic [CNT_W-1:0]     trp_cycles,
  input  logic [CNT_W-1:0]     txsr_cycles,
  input  logic [CNT_W-1:0]     dll_cycles,
  output logic                 cmd_pre_all,
  output logic                 cmd_sref,
  output logic                 cke,
  output logic                 in_sref,
  output logic                 sched_hold
);
  logic             sref_bit;
  logic             tmr_load, tmr_dec, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  sref_state_e      state_q;

  sref_ctrl_reg u_bit (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .req_pin(sref_req_pin), .bit_q(sref_bit)
  );

  sref_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .dec(tmr_dec), .expired(tmr_expired)
  );

  sref_fsm #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sref_bit(sref_bit), .burst_idle(burst_idle),
    .banks_open(banks_open), .trp_cycles(trp_cycles),
    .txsr_cycles(txsr_cycles), .dll_cycles(dll_cycles),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .tmr_dec(tmr_dec), .state_q(state_q)
  );

  assign cmd_pre_all = (state_q == ST_PRE);
  assign cmd_sref    = (state_q == ST_CMD);
  assign in_sref     = (state_q == ST_SR);
  assign cke         = (state_q != ST_SR);
  assign sched_hold  = sref_bit || (state_q != ST_IDLE);
endmodule

// File: rtl/sref_seq_chk.sv
module sref_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr_en,
  input logic cfg_wr_data,
  input logic sref_req_pin,
  input logic sref_bit,
  input logic cmd_pre_all,
  input logic cmd_sref,
  input logic cke,
  input logic sched_hold
);
  p_pin_sets_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sref_req_pin |=> sref_bit);

  p_clear_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sref_bit) |-> $past(cfg_wr_en && !cfg_wr_data && !sref_req_pin));

  p_hold_while_low_cke_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> sched_hold);

  p_pre_with_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre_all |-> (sched_hold && cke));

  p_cmd_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_pre_all, cmd_sref}));

  p_cke_drops_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sref |=> !cke);

  p_cke_fall_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(cmd_sref));
endmodule

bind sref_seq sref_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .sref_req_pin(sref_req_pin), .sref_bit(sref_bit), .cmd_pre_all(cmd_pre_all),
  .cmd_sref(cmd_sref), .cke(cke), .sched_hold(sched_hold)
);

// File: tb/sref_seq_test.sv
module sref_seq_test;
  localparam int NB = 8;
  localparam int W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0, cfg_wr_data = 1'b0, sref_req_pin = 1'b0;
  logic burst_idle = 1'b1;
  logic [NB-1:0] banks_open = '0;
  logic [W-1:0] trp_cycles = 8'd3, txsr_cycles = 8'd5, dll_cycles = 8'd4;
  logic cmd_pre_all, cmd_sref, cke, in_sref, sched_hold;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sref_seq #(.NUM_BANKS(NB), .CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .sref_req_pin(sref_req_pin), .burst_idle(burst_idle), .banks_open(banks_open),
    .trp_cycles(trp_cycles), .txsr_cycles(txsr_cycles), .dll_cycles(dll_cycles),
    .cmd_pre_all(cmd_pre_all), .cmd_sref(cmd_sref), .cke(cke),
    .in_sref(in_sref), .sched_hold(sched_hold)
  );

  // Behavioural reference: phase names a step of the sequence, rem a wait.
  int  phase = 0;
  int  rem = 0;
  bit  mbit = 0;

  function automatic int atleast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    bit nb;
    if (!rst_n) begin
      phase = 0; rem = 0; mbit = 0;
    end else begin
      nb = sref_req_pin ? 1'b1 : (cfg_wr_en ? cfg_wr_data : mbit);   // R1
      case (phase)
        0: if (mbit) phase = 1;                                      // R2
        1: if (burst_idle) phase = (banks_open != 0) ? 2 : 4;         // R3, R4
        2: begin rem = atleast1(int'(trp_cycles)); phase = 3; end     // R5
        3: begin rem--; if (rem == 0) phase = 4; end
        4: phase = 5;                                                 // R6
        5: if (!mbit) begin rem = atleast1(int'(txsr_cycles)); phase = 6; end // R7, R8
        6: begin rem--; if (rem == 0) begin rem = atleast1(int'(dll_cycles)); phase = 7; end end
        7: begin rem--; if (rem == 0) phase = 0; end                  // R9
        default: phase = 0;
      endcase
      mbit = nb;
    end
  end

  task automatic cmp(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      cmp("R4 cmd_pre_all", cmd_pre_all, phase == 2);
      cmp("R6 cmd_sref",    cmd_sref,    phase == 4);
      cmp("R8 cke",         cke,         phase != 5);
      cmp("R7 in_sref",     in_sref,     phase == 5);
      cmp("R9 sched_hold",  sched_hold,  mbit || phase != 0);
    end
  end

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic sw_write(input logic v);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    steps(1);
    cfg_wr_en = 1'b0;
  endtask

  task automatic pin_pulse();
    sref_req_pin = 1'b1;
    steps(1);
    sref_req_pin = 1'b0;
  endtask

  task automatic close_banks_after_pre();
    for (int i = 0; i < 40; i++) begin
      if (cmd_pre_all) begin steps(1); banks_open = '0; return; end
      steps(1);
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    steps(3);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    cmp("R10 cke", cke, 1'b1);
    cmp("R10 sched_hold", sched_hold, 1'b0);
    cmp("R10 cmd_pre_all", cmd_pre_all, 1'b0);
    cmp("R10 cmd_sref", cmd_sref, 1'b0);
    cmp("R10 in_sref", in_sref, 1'b0);
    steps(2);

    // R3 R4 R5: software entry, burst busy, banks open, trp=3
    burst_idle = 1'b0; banks_open = 8'h05;
    sw_write(1'b1);
    steps(4);
    burst_idle = 1'b1;
    close_banks_after_pre();
    steps(10);
    sw_write(1'b0);                       // R8 R9 exit with txsr=5, dll=4
    steps(15);

    // R1: pin and clearing write in the same cycle, pin wins; banks closed
    txsr_cycles = 8'd0; dll_cycles = 8'd1;
    sref_req_pin = 1'b1; cfg_wr_en = 1'b1; cfg_wr_data = 1'b0;
    steps(1);
    sref_req_pin = 1'b0; cfg_wr_en = 1'b0;
    steps(10);
    sw_write(1'b1);                       // R7 stays in self-refresh
    steps(3);
    sw_write(1'b0);
    steps(12);

    // R7: clear during a stalled drain, trp=0 edge
    trp_cycles = 8'd0; txsr_cycles = 8'd2; dll_cycles = 8'd0;
    burst_idle = 1'b0;
    sw_write(1'b1);
    steps(2);
    sw_write(1'b0);
    steps(3);
    banks_open = 8'h80; burst_idle = 1'b1;
    close_banks_after_pre();
    steps(12);

    // R9: new request during the exit wait keeps the hold up
    trp_cycles = 8'd2; txsr_cycles = 8'd6; dll_cycles = 8'd3;
    sw_write(1'b1);
    steps(6);
    sw_write(1'b0);
    steps(2);
    pin_pulse();
    steps(20);
    sw_write(1'b0);
    steps(20);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule